// File: doc/BRIEF.md
# Quad-channel prescaled pulse-width modulator

This block produces four independent pulse-width modulated outputs. Software programs it through a small synchronous register bus. The bus has a write strobe, a read strobe, a word address and 32-bit write and read data. One shared control word turns each channel on and picks its clock prescale ratio. One configuration word per channel holds the length of the period and the length of the high phase, both counted in prescaled steps. A mode word holds one select bit per channel. When that bit is set, the channel's pin is held low in place of the modulated waveform, which stands in for an alternate modulation scheme.

Each channel has its own prescaler, built from two cascaded sub-dividers, one dividing by 8 and one by 64. A 2-bit code chooses no division, either sub-divider alone, or both together for a division by 512. A 16-bit step counter advances once per prescaled tick. The pin is high while the step count is below the duty value. Period, duty and prescale settings are copied into per-channel shadow registers only when a period begins, so a change written while a channel runs never cuts a pulse short.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads zero, every channel is off, mode select is zero and all four outputs are low.
- R2: Word address 0 is the control word, word address 1+n is the configuration word of channel n, and word address 5 is the mode word. A read returns the stored 32-bit value in the cycle after the read strobe, and the read data holds its value while no read is strobed.
- R3: Control bit n enables channel n. A period starts on the clock edge after the write that sets the bit, and the output is high in that first step when the duty is nonzero and mode select is clear.
- R4: Control bits 4+2n and 5+2n hold channel n's divider code. Code 0 makes one step last 1 clock, code 1 makes it last 8, code 2 makes it last 64 and code 3 makes it last 512.
- R5: Bits 15:0 of a configuration word give the period in steps. The value 0 means 65536 steps.
- R6: Bits 31:16 of a configuration word give the duty. The output is high for the first duty steps of each period. A duty of 0 keeps it low, and a duty at or above the period keeps it high for the whole period.
- R7: Clearing a channel's enable bit drives its output low at once and clears its step counter and prescaler. Setting the bit again starts a full new period at step 0.
- R8: Period, duty and divider values written while a channel runs take effect only at the next period boundary. The period in progress completes unchanged.
- R9: Mode bit 4n set forces channel n's output low while the channel keeps counting. When the bit is cleared the output resumes the waveform in phase.
- R10: Channels run independently, each with its own divider, period and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_re | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NUM_CH (4) | Channel output pins |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and sub-dividers of 8 and 64. At these values the ratio 512 can be measured with short periods of a few steps. The largest period, 65536 steps selected by a period field of 0, fits in one measured cycle of about 65536 clocks at divider code 0. Exact clock counts of high phase and period are taken for every divider code. Further directed cases cover the enable start edge, a mid-period reconfiguration and the two channels of the independence test running at once.

// File: rtl/quad_pwm_pkg.sv
// Package: shared word addresses, field positions and divider codes for the
// quad-channel pulse-width modulator. Assumes at most four channels so that
// every per-channel field fits in one 32-bit word.
package quad_pwm_pkg;
    localparam int unsigned CTRL_WORD   = 0;
    localparam int unsigned CFG_WORD0   = 1;
    localparam int unsigned MODE_WORD   = 5;
    localparam int unsigned DIV_LSB     = 4;
    localparam int unsigned MODE_STRIDE = 4;
    localparam int unsigned DUTY_LSB    = 16;

    // Divider code: bit 0 engages the first sub-divider, bit 1 the second.
    typedef enum logic [1:0] {
        DIV_NONE = 2'd0,
        DIV_A    = 2'd1,
        DIV_B    = 2'd2,
        DIV_AB   = 2'd3
    } div_sel_e;
endpackage

// File: rtl/quad_pwm_regs.sv
// Module: register file with a synchronous word-addressed bus. Holds the
// control, per-channel configuration and mode words. Reads are registered
// and return the stored value the cycle after bus_re. Unmapped reads give 0.
module quad_pwm_regs
    import quad_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic                     bus_re,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [31:0]              ctrl_q,
    output logic [NUM_CH-1:0][31:0]  cfg_q,
    output logic [31:0]              mode_q
);
    logic [31:0] rd_mux;

    // Store written words into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            mode_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(CTRL_WORD)) ctrl_q <= bus_wdata;
            if (bus_addr == ADDR_W'(MODE_WORD)) mode_q <= bus_wdata;
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(CFG_WORD0 + i)) cfg_q[i] <= bus_wdata;
            end
        end
    end

    // Select the addressed register for reading.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(CTRL_WORD)) rd_mux = ctrl_q;
        if (bus_addr == ADDR_W'(MODE_WORD)) rd_mux = mode_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CFG_WORD0 + i)) rd_mux = cfg_q[i];
        end
    end

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/quad_pwm_presc.sv
// Module: two cascaded sub-dividers (SUB_A, then SUB_B) selected by a 2-bit
// code. Emits one tick per prescaled step. Assumes SUB_A and SUB_B are
// powers of two above 1. The clr input returns both counters to zero.
module quad_pwm_presc
    import quad_pwm_pkg::*;
#(
    parameter int SUB_A = 8,
    parameter int SUB_B = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  div_sel_e sel,
    output logic     tick
);
    localparam int A_W = $clog2(SUB_A);
    localparam int B_W = $clog2(SUB_B);

    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic           use_a, use_b, a_wrap, b_wrap, a_tick;

    // Decode the stage enables and wrap points.
    always_comb begin
        use_a  = sel[0];
        use_b  = sel[1];
        a_wrap = (a_cnt == A_W'(SUB_A - 1));
        b_wrap = (b_cnt == B_W'(SUB_B - 1));
        a_tick = use_a ? a_wrap : 1'b1;
        tick   = use_b ? (a_tick && b_wrap) : a_tick;
    end

    // Advance the first stage every clock and the second on first-stage ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            a_cnt <= '0;
            b_cnt <= '0;
        end else begin
            if (use_a)          a_cnt <= a_wrap ? '0 : a_cnt + 1'b1;
            if (use_b && a_tick) b_cnt <= b_wrap ? '0 : b_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/quad_pwm_chan.sv
// Module: one PWM channel. Loads period, duty and divider into shadows when a
// period starts, counts prescaled steps and drives the pin high while the step
// is below the duty. A period of 0 means 2**CNT_W steps. Disabling clears all
// state; hold_low masks the pin without stopping the count.
module quad_pwm_chan
    import quad_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SUB_A = 8,
    parameter int SUB_B = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold_low,
    input  div_sel_e         div_sel,
    input  logic [CNT_W-1:0] tb_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm
);
    logic             running;
    logic [CNT_W-1:0] step, tb_sh, duty_sh, last_step;
    div_sel_e         div_sh;
    logic             step_tick;

    quad_pwm_presc #(.SUB_A(SUB_A), .SUB_B(SUB_B)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en || !running),
        .sel   (div_sh),
        .tick  (step_tick)
    );

    // Last step index of the period; a zero period wraps to all ones.
    assign last_step = tb_sh - 1'b1;

    // Start, step and reload the period; clear everything when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running <= 1'b0;
            step    <= '0;
            tb_sh   <= '0;
            duty_sh <= '0;
            div_sh  <= DIV_NONE;
        end else if (!running || (step_tick && step == last_step)) begin
            running <= 1'b1;
            step    <= '0;
            tb_sh   <= tb_in;
            duty_sh <= duty_in;
            div_sh  <= div_sel;
        end else if (step_tick) begin
            step <= step + 1'b1;
        end
    end

    // Drive the pin from the compare, gated by enable and mode select.
    assign pwm = en && running && !hold_low && (step < duty_sh);
endmodule

// File: rtl/quad_pwm.sv
// Module: top of the quad-channel PWM. Splits the register words into
// per-channel fields and instantiates one channel per output. Assumes
// NUM_CH <= 4 and CNT_W <= 16 so that all fields fit their words.
module quad_pwm
    import quad_pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int SUB_A  = 8,
    parameter int SUB_B  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [31:0]                   ctrl_q, mode_q;
    logic [NUM_CH-1:0][31:0]       cfg_q;
    logic [NUM_CH-1:0]             ch_en, mode_sel;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_tb, ch_duty;
    logic [NUM_CH-1:0][1:0]        ch_div;

    quad_pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_q    (ctrl_q),
        .cfg_q     (cfg_q),
        .mode_q    (mode_q)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        // Extract this channel's fields from the register words.
        assign ch_en[n]    = ctrl_q[n];
        assign ch_div[n]   = ctrl_q[DIV_LSB + 2*n +: 2];
        assign mode_sel[n] = mode_q[MODE_STRIDE * n];
        assign ch_tb[n]    = cfg_q[n][CNT_W-1:0];
        assign ch_duty[n]  = cfg_q[n][DUTY_LSB +: CNT_W];

        quad_pwm_chan #(.CNT_W(CNT_W), .SUB_A(SUB_A), .SUB_B(SUB_B)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[n]),
            .hold_low (mode_sel[n]),
            .div_sel  (div_sel_e'(ch_div[n])),
            .tb_in    (ch_tb[n]),
            .duty_in  (ch_duty[n]),
            .pwm      (pwm_out[n])
        );
    end
endmodule

// File: rtl/quad_pwm_chk.sv
// Module: assertion checker bound into quad_pwm. Observes the bus, the pins
// and the decoded enable, mode and channel-0 duty fields.
module quad_pwm_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] mode_sel,
    input logic [CNT_W-1:0]  duty0
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0 && bus_rdata == '0 && ch_en == '0)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R2
    AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ch_en[0]) && !bus_we) |=>
        (pwm_out[0] == (ch_en[0] && !mode_sel[0] && duty0 != '0))); // R3
    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~ch_en) == '0)); // R7
    AST_MODE_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & mode_sel) == '0)); // R9
endmodule

bind quad_pwm quad_pwm_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en),
    .mode_sel  (mode_sel),
    .duty0     (ch_duty[0])
);

// File: tb/quad_pwm_tb_top.sv
// Directed bench for quad_pwm: one task per scenario, each checking itself.
module quad_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    function automatic logic [31:0] cfgw(input int duty, input int tb);
        return {duty[15:0], tb[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = addr[3:0]; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = addr[3:0];
        @(negedge clk);
        bus_re = 1'b0;
        data = bus_rdata;
    endtask

    // Wait for a low level then a rising edge; return high length and period.
    task automatic measure(input int ch, output int hi, output int per);
        int lo = 0;
        hi = 0;
        while (pwm_out[ch] !== 1'b0) @(negedge clk);
        while (pwm_out[ch] !== 1'b1) @(negedge clk);
        while (pwm_out[ch] === 1'b1) begin hi++; @(negedge clk); end
        while (pwm_out[ch] === 1'b0) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    function automatic int count_hi_dummy(input int x);
        return x;
    endfunction

    task automatic count_high(input int ch, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch] === 1'b1) highs++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(pwm_out == 4'b0, "R1 outputs low", pwm_out, 0);
        for (int a = 0; a < 6; a++) begin
            rd(a, v);
            check(v == 32'd0, "R1 register zero", v, 0);
        end
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(2, 32'h1234_5678);
        wr(5, 32'h0000_0100);
        rd(2, v);
        check(v == 32'h1234_5678, "R2 cfg readback", v, 32'h1234_5678);
        repeat (3) @(negedge clk);
        check(bus_rdata == 32'h1234_5678, "R2 read data holds", bus_rdata, 32'h1234_5678);
        rd(5, v);
        check(v == 32'h0000_0100, "R2 mode readback", v, 32'h100);
        check(pwm_out == 4'b0, "R2 mode word without enable leaves pins low", pwm_out, 0);
        wr(2, 0);
        wr(5, 0);
    endtask

    task automatic t_basic();
        int hi, per, highs;
        wr(1, cfgw(3, 10));
        wr(0, 32'h1);
        check(pwm_out[0] == 1'b0, "R3 low before start edge", pwm_out[0], 0);
        @(negedge clk);
        check(pwm_out[0] == 1'b1, "R3 high in first step", pwm_out[0], 1);
        measure(0, hi, per);
        check(hi == 3, "R6 high steps", hi, 3);
        check(per == 10, "R5 period steps", per, 10);
        repeat (1) @(negedge clk);
        wr(0, 32'h0);
        check(pwm_out[0] == 1'b0, "R7 low on disable", pwm_out[0], 0);
        count_high(0, 20, highs);
        check(highs == 0, "R7 stays low while off", highs, 0);
        wr(0, 32'h1);
        @(negedge clk);
        measure(0, hi, per);
        check(hi == 3 && per == 10, "R7 fresh period after re-enable", hi * 100 + per, 310);
        wr(0, 32'h0);
    endtask

    task automatic t_div();
        int hi, per;
        int d;
        for (int code = 1; code < 4; code++) begin
            d = (code == 1) ? 8 : (code == 2) ? 64 : 512;
            wr(2, cfgw(2, 4));
            wr(0, 32'h2 | (code << 6));
            measure(1, hi, per);
            check(hi == 2 * d, "R4 divided high length", hi, 2 * d);
            check(per == 4 * d, "R4 divided period", per, 4 * d);
            wr(0, 32'h0);
        end
    endtask

    task automatic t_edges();
        int highs;
        wr(3, cfgw(0, 5));
        wr(0, 32'h4);
        count_high(2, 20, highs);
        check(highs == 0, "R6 zero duty stays low", highs, 0);
        wr(0, 32'h0);
        wr(3, cfgw(7, 5));
        wr(0, 32'h4);
        @(negedge clk);
        count_high(2, 20, highs);
        check(highs == 20, "R6 duty above period stays high", highs, 20);
        wr(0, 32'h0);
    endtask

    task automatic t_midupdate();
        int hi, per, t0, t1;
        wr(4, cfgw(3, 10));
        wr(0, 32'h8);
        while (pwm_out[3] !== 1'b1) @(negedge clk);
        t0 = cyc;
        repeat (4) @(negedge clk);
        wr(4, cfgw(5, 6));
        while (pwm_out[3] !== 1'b1) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 10, "R8 running period finishes unchanged", t1 - t0, 10);
        measure(3, hi, per);
        check(hi == 5 && per == 6, "R8 new values at boundary", hi * 100 + per, 506);
        wr(0, 32'h0);
    endtask

    task automatic t_mode();
        int hi, per, highs;
        wr(1, cfgw(3, 10));
        wr(0, 32'h1);
        wr(5, 32'h1);
        count_high(0, 30, highs);
        check(highs == 0, "R9 mode select holds low", highs, 0);
        wr(5, 32'h0);
        measure(0, hi, per);
        check(hi == 3 && per == 10, "R9 waveform resumes", hi * 100 + per, 310);
        wr(0, 32'h0);
    endtask

    task automatic t_indep();
        int hi, per;
        wr(1, cfgw(2, 5));
        wr(2, cfgw(1, 2));
        wr(0, 32'h3 | (1 << 6));
        measure(0, hi, per);
        check(hi == 2 && per == 5, "R10 channel 0 alongside channel 1", hi * 100 + per, 205);
        measure(1, hi, per);
        check(hi == 8 && per == 16, "R10 channel 1 alongside channel 0", hi * 100 + per, 816);
        wr(0, 32'h0);
    endtask

    task automatic t_long();
        int hi, per;
        wr(3, cfgw(32768, 0));
        wr(0, 32'h4);
        measure(2, hi, per);
        check(hi == 32768, "R5 long high phase", hi, 32768);
        check(per == 65536, "R5 zero period field means 65536", per, 65536);
        wr(0, 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_basic();
        t_div();
        t_edges();
        t_midupdate();
        t_mode();
        t_indep();
        t_long();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule